// File: doc/BRIEF.md
# I2C Master Engine Register Front End

This block is the register-side front end of a polled I2C master engine. A simple 32-bit register bus (byte address, read strobe, write strobe, write data, registered read data) reaches it. Several word offsets mean one thing on a read and another on a write. A read returns a status or condition word. A write acts as a strobe: it sets or clears mask bits, resets the engine, clears errors or moves a bus line. The block holds the mode, interrupt-mask and watermark registers. It composes the status, extended-status, interrupt-condition and pending words from the engine's status inputs. It turns writes into one-cycle pulses for the command launcher, the data FIFO and the engine.

While the diagnostic bit of the mode register is set, software drives the SCL and SDA pull-down enables directly through four write-only offsets. Otherwise the bit engine owns both lines. Both line inputs pass through a two-flop synchronizer before they reach the status words. The port field of the mode register is decoded into one enable per physical port. A sticky port-busy flag is set by the engine and cleared by software.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After reset, the mode word (offset 0x08) reads `{CLKDIV_RST, 16'h0000}`, the mask (0x10) reads 0, both pull-down enables follow the engine inputs, and only port enable 0 is high.
- R2: Mode (0x08) stores bits 31:16 as the clock divider, bits 15:10 as the port, and bit 3 enhanced, bit 2 diagnostic, bit 1 pacing, bit 0 wrap; bits 9:4 read 0. Watermark (0x0C) stores only bits 15:12 (high mark) and 7:4 (low mark).
- R3: The mask is written whole at 0x10, bitwise ORed by a write to 0x14 and bitwise ANDed by a write to 0x18; mask bits 4:0 always read 0.
- R4: A read of 0x14 returns the conditions: bits 15:7 are the nine engine flags, bit 6 engine busy, bit 5 engine idle. A read of 0x18 returns the conditions ANDed with the mask. Status bit 15 is set when any pending bit is set.
- R5: Status (0x1C read) has flags in 31:23, the highest port index in 19:16, the pending indication in 15, the synchronized SCL in 11 and SDA in 10, sticky port busy in 9, engine busy in 8 and the FIFO count in 7:0.
- R6: Extended status (0x20 read) has FIFO depth in 31:24, synchronized SCL/SDA in 15:14, far-side SCL/SDA in 13:12, the driven SCL/SDA levels in 11:10, high-water (count >= high mark) in 9, low-water (count <= low mark) in 8, port busy in 7, engine busy in 6 and the version in 4:0.
- R7: A write to 0x1C gives a one-cycle `eng_reset` pulse and returns the whole mode word to its reset value, which makes the port 0 and the divider `CLKDIV_RST`.
- R8: A write to 0x04 gives a one-cycle `cmd_go` with the written word on `cmd_word`. A write to 0x00 pulses `fifo_push` with the data. A read of 0x00 returns `fifo_rdata` and pulses `fifo_pop`. A write to 0x20 pulses `err_clear`. A read of 0x24 returns the residual length in bits 15:0.
- R9: In diagnostic mode a write to 0x2C pulls SCL low, 0x24 releases SCL, 0x34 pulls SDA low and 0x30 releases SDA, whatever the data.
- R10: With diagnostic mode off, the pull-down enables equal the engine requests, the four line offsets have no effect, and the manual state returns to released.
- R11: The SCL and SDA inputs reach the status words through two flops, so a read sampled at the first edge after an input change still returns the old level.
- R12: A one-cycle engine port-busy pulse sets a sticky flag, readable at 0x28 bit 31. A write to 0x28 clears it only when data bit 31 is 1.
- R13: `port_en[p]` is high only when the mode port field equals p. A port number above `MAX_PORT` enables no port.
- R14: Reads of the write-only offsets 0x04, 0x2C, 0x30, 0x34 and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| cmd_go | output | 1 | Command launch pulse |
| cmd_word | output | 32 | Last command word written |
| fifo_push | output | 1 | FIFO write pulse |
| fifo_wdata | output | 32 | FIFO write data |
| fifo_pop | output | 1 | FIFO read pulse |
| fifo_rdata | input | 32 | FIFO head data |
| eng_reset | output | 1 | Engine reset pulse |
| err_clear | output | 1 | Error-flag clear pulse |
| eng_flags | input | 9 | Engine error, data-request and complete flags |
| eng_busy | input | 1 | Engine busy |
| eng_fifo_count | input | 8 | FIFO fill count |
| eng_resid | input | 16 | Residual transfer length |
| eng_port_busy | input | 1 | Port-busy event |
| far_scl | input | 1 | Far-side SCL level |
| far_sda | input | 1 | Far-side SDA level |
| eng_scl_low | input | 1 | Engine request to pull SCL low |
| eng_sda_low | input | 1 | Engine request to pull SDA low |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_low_en | output | 1 | SCL pull-down enable |
| sda_low_en | output | 1 | SDA pull-down enable |
| clk_div | output | 16 | Clock divider |
| port_sel | output | 6 | Selected port number |
| port_en | output | MAX_PORT+1 | One enable per physical port |
| mode_enh | output | 1 | Enhanced mode |
| mode_pace | output | 1 | Pacing allowed |
| mode_wrap | output | 1 | Wrap mode |
| wm_high | output | 4 | High watermark |
| wm_low | output | 4 | Low watermark |

## Verification
The assertions assume that one register access at most is decoded per cycle, so the mode word and the line strobes never change in the same edge. They also assume that the engine does not raise its port-busy event in the cycle that software clears the sticky flag. The bench drives every access from a task on the falling edge, one access per two cycles. It changes engine and line inputs only between accesses and keeps `eng_port_busy` low during clear writes. Thus each check sees the effect of a single access.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  // Word indices (byte offset / 4); writes and reads share some of them
  localparam logic [3:0] IX_FIFO  = 4'd0;
  localparam logic [3:0] IX_CMD   = 4'd1;
  localparam logic [3:0] IX_MODE  = 4'd2;
  localparam logic [3:0] IX_WMARK = 4'd3;
  localparam logic [3:0] IX_MASK  = 4'd4;
  localparam logic [3:0] IX_COND  = 4'd5;  // read conditions / write OR mask
  localparam logic [3:0] IX_PEND  = 4'd6;  // read pending / write AND mask
  localparam logic [3:0] IX_STAT  = 4'd7;  // read status / write engine reset
  localparam logic [3:0] IX_XSTAT = 4'd8;  // read ext status / write error clear
  localparam logic [3:0] IX_RESID = 4'd9;  // read residual / write SCL release
  localparam logic [3:0] IX_PBUSY = 4'd10;
  localparam logic [3:0] IX_SCLLO = 4'd11;
  localparam logic [3:0] IX_SDAHI = 4'd12;
  localparam logic [3:0] IX_SDALO = 4'd13;

  localparam int IDX_LSB = 2;
  localparam int IDX_W   = 4;

  localparam int MODE_WRAP = 0;
  localparam int MODE_PACE = 1;
  localparam int MODE_DIAG = 2;
  localparam int MODE_ENH  = 3;
  localparam int PORT_LSB  = 10;
  localparam int PORT_W    = 6;
  localparam int DIV_LSB   = 16;
  localparam int DIV_W     = 16;

  localparam logic [31:0] MODE_WMASK  = 32'hFFFF_FC0F;
  localparam logic [31:0] WMARK_WMASK = 32'h0000_F0F0;
  localparam logic [15:0] MASK_WMASK  = 16'hFFE0;
  localparam int          PBUSY_KEY   = 31;

  typedef struct packed {
    logic fifo;
    logic cmd;
    logic mode;
    logic wmark;
    logic mask_ld;
    logic mask_or;
    logic mask_and;
    logic eng_rst;
    logic err_clr;
    logic scl_rel;
    logic pbusy;
    logic scl_pull;
    logic sda_rel;
    logic sda_pull;
  } wr_stb_t;

endpackage

// File: rtl/i2cr_decode.sv
module i2cr_decode
  import i2cr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output wr_stb_t           wr_stb,
  output logic              rd_hit,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              cmd_go,
  output logic [31:0]       cmd_word,
  output logic              fifo_push,
  output logic [31:0]       fifo_wdata,
  output logic              fifo_pop,
  output logic              eng_reset,
  output logic              err_clear
);

  logic [IDX_W-1:0] widx;
  logic             in_range;

  assign widx = bus_addr[IDX_LSB +: IDX_W];

  generate
    if (ADDR_W > IDX_LSB + IDX_W) begin : g_upper
      assign in_range = ~|bus_addr[ADDR_W-1:IDX_LSB+IDX_W];
    end else begin : g_exact
      assign in_range = 1'b1;
    end
  endgenerate

  always_comb begin
    wr_stb = '0;
    if (bus_wr && in_range) begin
      case (widx)
        IX_FIFO:  wr_stb.fifo     = 1'b1;
        IX_CMD:   wr_stb.cmd      = 1'b1;
        IX_MODE:  wr_stb.mode     = 1'b1;
        IX_WMARK: wr_stb.wmark    = 1'b1;
        IX_MASK:  wr_stb.mask_ld  = 1'b1;
        IX_COND:  wr_stb.mask_or  = 1'b1;
        IX_PEND:  wr_stb.mask_and = 1'b1;
        IX_STAT:  wr_stb.eng_rst  = 1'b1;
        IX_XSTAT: wr_stb.err_clr  = 1'b1;
        IX_RESID: wr_stb.scl_rel  = 1'b1;
        IX_PBUSY: wr_stb.pbusy    = 1'b1;
        IX_SCLLO: wr_stb.scl_pull = 1'b1;
        IX_SDAHI: wr_stb.sda_rel  = 1'b1;
        IX_SDALO: wr_stb.sda_pull = 1'b1;
        default:  wr_stb = '0;
      endcase
    end
  end

  assign rd_hit = bus_rd && in_range;
  assign rd_idx = widx;

  // Registered pulses toward engine and FIFO
  logic        cmd_go_d, fifo_push_d, fifo_pop_d, eng_reset_d, err_clear_d;
  logic [31:0] cmd_word_d, fifo_wdata_d;

  always_comb begin
    cmd_go_d     = wr_stb.cmd;
    fifo_push_d  = wr_stb.fifo;
    fifo_pop_d   = rd_hit && (widx == IX_FIFO);
    eng_reset_d  = wr_stb.eng_rst;
    err_clear_d  = wr_stb.err_clr;
    cmd_word_d   = cmd_word;
    fifo_wdata_d = fifo_wdata;
    if (wr_stb.cmd)  cmd_word_d   = bus_wdata;
    if (wr_stb.fifo) fifo_wdata_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_go     <= 1'b0;
      fifo_push  <= 1'b0;
      fifo_pop   <= 1'b0;
      eng_reset  <= 1'b0;
      err_clear  <= 1'b0;
      cmd_word   <= '0;
      fifo_wdata <= '0;
    end else begin
      cmd_go     <= cmd_go_d;
      fifo_push  <= fifo_push_d;
      fifo_pop   <= fifo_pop_d;
      eng_reset  <= eng_reset_d;
      err_clear  <= err_clear_d;
      cmd_word   <= cmd_word_d;
      fifo_wdata <= fifo_wdata_d;
    end
  end

  // R8: a command write launches exactly the written word next cycle
  p_cmd_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb.cmd |=> (cmd_go && cmd_word == $past(bus_wdata)));

  // R8: a FIFO read produces the pop pulse next cycle
  p_fifo_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && rd_idx == IX_FIFO) |=> fifo_pop);

endmodule

// File: rtl/i2cr_cfg.sv
module i2cr_cfg
  import i2cr_pkg::*;
#(
  parameter logic [15:0] CLKDIV_RST = 16'h0006
) (
  input  logic        clk,
  input  logic        rst_n,
  input  wr_stb_t     wr_stb,
  input  logic [31:0] wdata,
  output logic [31:0] mode_q,
  output logic [15:0] mask_q,
  output logic [31:0] wmark_q
);

  localparam logic [31:0] MODE_RST = {CLKDIV_RST, 16'h0000};

  logic [31:0] mode_d, wmark_d;
  logic [15:0] mask_d, wmask_in;

  assign wmask_in = wdata[15:0] & MASK_WMASK;

  always_comb begin
    mode_d = mode_q;
    if (wr_stb.eng_rst)   mode_d = MODE_RST;
    else if (wr_stb.mode) mode_d = wdata & MODE_WMASK;
  end

  always_comb begin
    mask_d = mask_q;
    if (wr_stb.mask_ld)       mask_d = wmask_in;
    else if (wr_stb.mask_or)  mask_d = mask_q | wmask_in;
    else if (wr_stb.mask_and) mask_d = mask_q & wmask_in;
  end

  always_comb begin
    wmark_d = wmark_q;
    if (wr_stb.wmark) wmark_d = wdata & WMARK_WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST;
      mask_q  <= '0;
      wmark_q <= '0;
    end else begin
      mode_q  <= mode_d;
      mask_q  <= mask_d;
      wmark_q <= wmark_d;
    end
  end

  // R7: engine reset returns port to 0 and divider to its default
  p_eng_rst_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb.eng_rst |=> (mode_q[PORT_LSB +: PORT_W] == '0 &&
                        mode_q[DIV_LSB +: DIV_W] == CLKDIV_RST));

  // R3: OR write leaves every written one set
  p_mask_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb.mask_or |=> ((mask_q & $past(wmask_in)) == $past(wmask_in)));

  // R3: AND write leaves no bit set outside the written ones
  p_mask_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb.mask_and |=> ((mask_q & ~$past(wmask_in)) == '0));

endmodule

// File: rtl/i2cr_line.sv
module i2cr_line #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic diag,
  input  logic scl_rel,
  input  logic scl_pull,
  input  logic sda_rel,
  input  logic sda_pull,
  input  logic eng_scl_low,
  input  logic eng_sda_low,
  input  logic scl_in,
  input  logic sda_in,
  input  logic pbusy_set,
  input  logic pbusy_clr,
  output logic scl_low_en,
  output logic sda_low_en,
  output logic scl_sync,
  output logic sda_sync,
  output logic pbusy_q
);

  // Input synchronizers, reset to the idle-high bus level
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      logic scl_src, sda_src;
      if (s == 0) begin : g_first
        assign scl_src = scl_in;
        assign sda_src = sda_in;
      end else begin : g_next
        assign scl_src = scl_sh[s-1];
        assign sda_src = sda_sh[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh[s] <= 1'b1;
          sda_sh[s] <= 1'b1;
        end else begin
          scl_sh[s] <= scl_src;
          sda_sh[s] <= sda_src;
        end
      end
    end
  endgenerate

  assign scl_sync = scl_sh[SYNC_STAGES-1];
  assign sda_sync = sda_sh[SYNC_STAGES-1];

  // Manual pull-down state, only live in diagnostic mode
  logic scl_man_q, sda_man_q, scl_man_d, sda_man_d, pbusy_d;

  always_comb begin
    scl_man_d = scl_man_q;
    sda_man_d = sda_man_q;
    if (!diag) begin
      scl_man_d = 1'b0;
      sda_man_d = 1'b0;
    end else begin
      if (scl_pull)     scl_man_d = 1'b1;
      else if (scl_rel) scl_man_d = 1'b0;
      if (sda_pull)     sda_man_d = 1'b1;
      else if (sda_rel) sda_man_d = 1'b0;
    end
  end

  always_comb begin
    pbusy_d = pbusy_q;
    if (pbusy_set)      pbusy_d = 1'b1;
    else if (pbusy_clr) pbusy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_man_q <= 1'b0;
      sda_man_q <= 1'b0;
      pbusy_q   <= 1'b0;
    end else begin
      scl_man_q <= scl_man_d;
      sda_man_q <= sda_man_d;
      pbusy_q   <= pbusy_d;
    end
  end

  assign scl_low_en = diag ? scl_man_q : eng_scl_low;
  assign sda_low_en = diag ? sda_man_q : eng_sda_low;

  // R9: a manual SCL pull in diagnostic mode drives the line low next cycle
  p_diag_scl_pull_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (diag && scl_pull) |=> scl_low_en);

  // R9: a manual SDA release in diagnostic mode frees the line next cycle
  p_diag_sda_rel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (diag && sda_rel) |=> !sda_low_en);

  // R10: outside diagnostic mode the manual state returns to released
  p_nodiag_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !diag |=> (!scl_man_q && !sda_man_q));

  // R12: a keyed clear with no new event drops the sticky flag
  p_pbusy_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pbusy_clr && !pbusy_set) |=> !pbusy_q);

endmodule

// File: rtl/i2cr_rdmux.sv
module i2cr_rdmux
  import i2cr_pkg::*;
#(
  parameter int          MAX_PORT   = 3,
  parameter logic [7:0]  FIFO_DEPTH = 8'd16,
  parameter logic [4:0]  VERSION    = 5'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_hit,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [31:0]      mode_q,
  input  logic [15:0]      mask_q,
  input  logic [31:0]      wmark_q,
  input  logic [31:0]      fifo_rdata,
  input  logic [8:0]       eng_flags,
  input  logic             eng_busy,
  input  logic [7:0]       eng_fifo_count,
  input  logic [15:0]      eng_resid,
  input  logic             far_scl,
  input  logic             far_sda,
  input  logic             scl_sync,
  input  logic             sda_sync,
  input  logic             scl_low_en,
  input  logic             sda_low_en,
  input  logic             pbusy_q,
  output logic [31:0]      rdata_q
);

  logic [15:0] cond, pend;
  logic        any_pend, hi_water, lo_water;
  logic [31:0] stat_w, xstat_w, sel_w, rdata_d;
  logic [3:0]  wm_hi, wm_lo;

  assign wm_hi = wmark_q[15:12];
  assign wm_lo = wmark_q[7:4];

  always_comb begin
    cond     = {eng_flags, eng_busy, ~eng_busy, 5'b00000};
    pend     = cond & mask_q;
    any_pend = |pend;
    hi_water = eng_fifo_count >= {4'b0000, wm_hi};
    lo_water = eng_fifo_count <= {4'b0000, wm_lo};
    stat_w   = {eng_flags, 3'b000, 4'(MAX_PORT), any_pend, 3'b000,
                scl_sync, sda_sync, pbusy_q, eng_busy, eng_fifo_count};
    xstat_w  = {FIFO_DEPTH, 8'h00, scl_sync, sda_sync, far_scl, far_sda,
                ~scl_low_en, ~sda_low_en, hi_water, lo_water,
                pbusy_q, eng_busy, 1'b0, VERSION};
  end

  always_comb begin
    case (rd_idx)
      IX_FIFO:  sel_w = fifo_rdata;
      IX_MODE:  sel_w = mode_q;
      IX_WMARK: sel_w = wmark_q;
      IX_MASK:  sel_w = {16'h0000, mask_q};
      IX_COND:  sel_w = {16'h0000, cond};
      IX_PEND:  sel_w = {16'h0000, pend};
      IX_STAT:  sel_w = stat_w;
      IX_XSTAT: sel_w = xstat_w;
      IX_RESID: sel_w = {16'h0000, eng_resid};
      IX_PBUSY: sel_w = {pbusy_q, 31'h0};
      default:  sel_w = 32'h0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_hit) rdata_d = sel_w;
    else if (rd_idx == IX_FIFO && !rd_hit) rdata_d = rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  // R14: write-only offsets read back as zero
  p_wo_zero_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && (rd_idx == IX_CMD || rd_idx == IX_SCLLO ||
                rd_idx == IX_SDAHI || rd_idx == IX_SDALO)) |=> (rdata_q == '0));

  // R3: mask bits below the condition field read zero
  p_mask_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && rd_idx == IX_MASK) |=> (rdata_q[4:0] == '0));

endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2cr_pkg::*;
#(
  parameter int          ADDR_W      = 6,
  parameter int          MAX_PORT    = 3,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] CLKDIV_RST  = 16'h0006,
  parameter logic [7:0]  FIFO_DEPTH  = 8'd16,
  parameter logic [4:0]  VERSION     = 5'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cmd_go,
  output logic [31:0]       cmd_word,
  output logic              fifo_push,
  output logic [31:0]       fifo_wdata,
  output logic              fifo_pop,
  input  logic [31:0]       fifo_rdata,
  output logic              eng_reset,
  output logic              err_clear,
  input  logic [8:0]        eng_flags,
  input  logic              eng_busy,
  input  logic [7:0]        eng_fifo_count,
  input  logic [15:0]       eng_resid,
  input  logic              eng_port_busy,
  input  logic              far_scl,
  input  logic              far_sda,
  input  logic              eng_scl_low,
  input  logic              eng_sda_low,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_low_en,
  output logic              sda_low_en,
  output logic [15:0]       clk_div,
  output logic [5:0]        port_sel,
  output logic [MAX_PORT:0] port_en,
  output logic              mode_enh,
  output logic              mode_pace,
  output logic              mode_wrap,
  output logic [3:0]        wm_high,
  output logic [3:0]        wm_low
);

  localparam int NUM_PORTS = MAX_PORT + 1;

  // Reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  wr_stb_t          wr_stb;
  logic             rd_hit;
  logic [IDX_W-1:0] rd_idx;
  logic [31:0]      mode_q, wmark_q;
  logic [15:0]      mask_q;
  logic             scl_sync, sda_sync, pbusy_q;

  i2cr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .wr_stb     (wr_stb),
    .rd_hit     (rd_hit),
    .rd_idx     (rd_idx),
    .cmd_go     (cmd_go),
    .cmd_word   (cmd_word),
    .fifo_push  (fifo_push),
    .fifo_wdata (fifo_wdata),
    .fifo_pop   (fifo_pop),
    .eng_reset  (eng_reset),
    .err_clear  (err_clear)
  );

  i2cr_cfg #(.CLKDIV_RST(CLKDIV_RST)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_stb  (wr_stb),
    .wdata   (bus_wdata),
    .mode_q  (mode_q),
    .mask_q  (mask_q),
    .wmark_q (wmark_q)
  );

  i2cr_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .diag        (mode_q[MODE_DIAG]),
    .scl_rel     (wr_stb.scl_rel),
    .scl_pull    (wr_stb.scl_pull),
    .sda_rel     (wr_stb.sda_rel),
    .sda_pull    (wr_stb.sda_pull),
    .eng_scl_low (eng_scl_low),
    .eng_sda_low (eng_sda_low),
    .scl_in      (scl_in),
    .sda_in      (sda_in),
    .pbusy_set   (eng_port_busy),
    .pbusy_clr   (wr_stb.pbusy && bus_wdata[PBUSY_KEY]),
    .scl_low_en  (scl_low_en),
    .sda_low_en  (sda_low_en),
    .scl_sync    (scl_sync),
    .sda_sync    (sda_sync),
    .pbusy_q     (pbusy_q)
  );

  i2cr_rdmux #(
    .MAX_PORT   (MAX_PORT),
    .FIFO_DEPTH (FIFO_DEPTH),
    .VERSION    (VERSION)
  ) u_rdmux (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .rd_hit         (rd_hit),
    .rd_idx         (rd_idx),
    .mode_q         (mode_q),
    .mask_q         (mask_q),
    .wmark_q        (wmark_q),
    .fifo_rdata     (fifo_rdata),
    .eng_flags      (eng_flags),
    .eng_busy       (eng_busy),
    .eng_fifo_count (eng_fifo_count),
    .eng_resid      (eng_resid),
    .far_scl        (far_scl),
    .far_sda        (far_sda),
    .scl_sync       (scl_sync),
    .sda_sync       (sda_sync),
    .scl_low_en     (scl_low_en),
    .sda_low_en     (sda_low_en),
    .pbusy_q        (pbusy_q),
    .rdata_q        (bus_rdata)
  );

  assign clk_div   = mode_q[DIV_LSB +: DIV_W];
  assign port_sel  = mode_q[PORT_LSB +: PORT_W];
  assign mode_enh  = mode_q[MODE_ENH];
  assign mode_pace = mode_q[MODE_PACE];
  assign mode_wrap = mode_q[MODE_WRAP];
  assign wm_high   = wmark_q[15:12];
  assign wm_low    = wmark_q[7:4];

  // Port number to one-hot physical port enable
  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign port_en[p] = (port_sel == PORT_W'(p));
    end
  endgenerate

  // R13: never more than one physical port enabled
  p_port_onehot_r13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(port_en));

endmodule

// File: tb/test_i2c_ctl_regs.sv
module test_i2c_ctl_regs;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        cmd_go, fifo_push, fifo_pop, eng_reset, err_clear;
  logic [31:0] cmd_word, fifo_wdata, fifo_rdata;
  logic [8:0]  eng_flags;
  logic        eng_busy, eng_port_busy, far_scl, far_sda;
  logic [7:0]  eng_fifo_count;
  logic [15:0] eng_resid;
  logic        eng_scl_low, eng_sda_low, scl_in, sda_in;
  logic        scl_low_en, sda_low_en;
  logic [15:0] clk_div;
  logic [5:0]  port_sel;
  logic [3:0]  port_en;
  logic        mode_enh, mode_pace, mode_wrap;
  logic [3:0]  wm_high, wm_low;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  i2c_ctl_regs i_i2c_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_go(cmd_go), .cmd_word(cmd_word), .fifo_push(fifo_push),
    .fifo_wdata(fifo_wdata), .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
    .eng_reset(eng_reset), .err_clear(err_clear), .eng_flags(eng_flags),
    .eng_busy(eng_busy), .eng_fifo_count(eng_fifo_count),
    .eng_resid(eng_resid), .eng_port_busy(eng_port_busy),
    .far_scl(far_scl), .far_sda(far_sda), .eng_scl_low(eng_scl_low),
    .eng_sda_low(eng_sda_low), .scl_in(scl_in), .sda_in(sda_in),
    .scl_low_en(scl_low_en), .sda_low_en(sda_low_en), .clk_div(clk_div),
    .port_sel(port_sel), .port_en(port_en), .mode_enh(mode_enh),
    .mode_pace(mode_pace), .mode_wrap(mode_wrap), .wm_high(wm_high),
    .wm_low(wm_low)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(6'h08, d); chk("R1 mode reset", d, 32'h0006_0000);
    rd(6'h10, d); chk("R1 mask reset", d, 32'h0);
    chk("R1 lines follow engine", {30'b0, scl_low_en, sda_low_en}, 32'h0);
    chk("R1 port enable", {28'b0, port_en}, 32'h1);
  endtask

  task automatic t_mode;
    logic [31:0] d;
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, d); chk("R2 mode ro bits", d, 32'hFFFF_FC0F);
    chk("R13 out-of-range port", {28'b0, port_en}, 32'h0);
    wr(6'h08, 32'h0010_080B);
    rd(6'h08, d); chk("R2 mode readback", d, 32'h0010_080B);
    chk("R2 mode outputs", {clk_div, 10'b0, port_sel}, {16'h0010, 10'b0, 6'd2});
    chk("R2 mode flags", {29'b0, mode_enh, mode_pace, mode_wrap}, 32'h7);
    chk("R13 port 2 enable", {28'b0, port_en}, 32'h4);
    wr(6'h0C, 32'hFFFF_FFFF);
    rd(6'h0C, d); chk("R2 watermark bits", d, 32'h0000_F0F0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(6'h10, 32'h0000_FFFF);
    rd(6'h10, d); chk("R3 mask load", d, 32'h0000_FFE0);
    wr(6'h10, 32'h0000_0300);
    wr(6'h14, 32'h0000_8000);
    rd(6'h10, d); chk("R3 mask or", d, 32'h0000_8300);
    wr(6'h18, 32'h0000_8100);
    rd(6'h10, d); chk("R3 mask and", d, 32'h0000_8100);
  endtask

  task automatic t_int_stat;
    logic [31:0] d;
    eng_flags = 9'h002; eng_busy = 1'b0; eng_fifo_count = 8'd5;
    rd(6'h14, d); chk("R4 conditions", d, 32'h0000_0120);
    rd(6'h18, d); chk("R4 pending", d, 32'h0000_0100);
    rd(6'h1C, d); chk("R5 status any pending", d, 32'h0103_8C05);
    wr(6'h10, 32'h0);
    rd(6'h18, d); chk("R4 pending masked", d, 32'h0);
    rd(6'h1C, d); chk("R5 status no pending", d, 32'h0103_0C05);
  endtask

  task automatic t_xstat;
    logic [31:0] d;
    wr(6'h0C, 32'h0000_C040);
    eng_busy = 1'b1; far_scl = 1'b1; far_sda = 1'b0;
    rd(6'h20, d); chk("R6 ext status mid", d, 32'h1000_EC43);
    eng_fifo_count = 8'd2;
    rd(6'h20, d); chk("R6 low water", d, 32'h1000_ED43);
    eng_fifo_count = 8'd12;
    rd(6'h20, d); chk("R6 high water", d, 32'h1000_EE43);
    eng_busy = 1'b0;
  endtask

  task automatic t_actions;
    logic [31:0] d;
    wr(6'h04, 32'hC004_0003);
    chk("R8 cmd pulse", {31'b0, cmd_go}, 32'h1);
    chk("R8 cmd word", cmd_word, 32'hC004_0003);
    @(negedge clk); chk("R8 cmd pulse width", {31'b0, cmd_go}, 32'h0);
    wr(6'h00, 32'h0000_00A5);
    chk("R8 fifo push", {31'b0, fifo_push}, 32'h1);
    chk("R8 fifo data", fifo_wdata, 32'h0000_00A5);
    fifo_rdata = 32'h0000_005A;
    rd(6'h00, d);
    chk("R8 fifo read data", d, 32'h0000_005A);
    chk("R8 fifo pop", {31'b0, fifo_pop}, 32'h1);
    wr(6'h20, 32'h0);
    chk("R8 error clear", {31'b0, err_clear}, 32'h1);
    eng_resid = 16'h1234;
    rd(6'h24, d); chk("R8 residual", d, 32'h0000_1234);
  endtask

  task automatic t_eng_reset;
    logic [31:0] d;
    wr(6'h08, 32'h0010_0C04);
    chk("R13 port 3 enable", {28'b0, port_en}, 32'h8);
    wr(6'h1C, 32'h0);
    chk("R7 reset pulse", {31'b0, eng_reset}, 32'h1);
    @(negedge clk); chk("R7 reset pulse width", {31'b0, eng_reset}, 32'h0);
    rd(6'h08, d); chk("R7 mode after reset", d, 32'h0006_0000);
    chk("R7 port 0 enable", {28'b0, port_en}, 32'h1);
  endtask

  task automatic t_diag;
    logic [31:0] d;
    eng_scl_low = 1'b1; eng_sda_low = 1'b1;
    wr(6'h08, 32'h0006_0004);
    chk("R9 diag entry released", {30'b0, scl_low_en, sda_low_en}, 32'h0);
    wr(6'h2C, 32'h0);
    chk("R9 scl pull", {30'b0, scl_low_en, sda_low_en}, 32'h2);
    rd(6'h20, d); chk("R9 driven scl in ext status", {31'b0, d[11]}, 32'h0);
    wr(6'h34, 32'hFFFF_FFFF);
    chk("R9 sda pull", {30'b0, scl_low_en, sda_low_en}, 32'h3);
    wr(6'h24, 32'h0);
    chk("R9 scl release", {30'b0, scl_low_en, sda_low_en}, 32'h1);
    wr(6'h30, 32'h0);
    chk("R9 sda release", {30'b0, scl_low_en, sda_low_en}, 32'h0);
  endtask

  task automatic t_nodiag;
    wr(6'h2C, 32'h0);
    wr(6'h08, 32'h0006_0000);
    chk("R10 engine owns lines", {30'b0, scl_low_en, sda_low_en}, 32'h3);
    eng_scl_low = 1'b0; eng_sda_low = 1'b0;
    wr(6'h2C, 32'h0);
    wr(6'h34, 32'h0);
    chk("R10 strobes ignored", {30'b0, scl_low_en, sda_low_en}, 32'h0);
    wr(6'h08, 32'h0006_0004);
    chk("R10 manual state released", {30'b0, scl_low_en, sda_low_en}, 32'h0);
    wr(6'h08, 32'h0006_0000);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    @(negedge clk);
    scl_in = 1'b0;
    rd(6'h1C, d); chk("R11 first read old scl", {31'b0, d[11]}, 32'h1);
    repeat (2) @(negedge clk);
    rd(6'h1C, d); chk("R11 synced scl", {31'b0, d[11]}, 32'h0);
    scl_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_pbusy;
    logic [31:0] d;
    @(negedge clk); eng_port_busy = 1'b1;
    @(negedge clk); eng_port_busy = 1'b0;
    rd(6'h28, d); chk("R12 sticky set", d, 32'h8000_0000);
    rd(6'h1C, d); chk("R12 status port busy", {31'b0, d[9]}, 32'h1);
    wr(6'h28, 32'h7FFF_FFFF);
    rd(6'h28, d); chk("R12 unkeyed clear ignored", d, 32'h8000_0000);
    wr(6'h28, 32'h8000_0000);
    rd(6'h28, d); chk("R12 keyed clear", d, 32'h0);
    rd(6'h1C, d); chk("R12 status cleared", {31'b0, d[9]}, 32'h0);
  endtask

  task automatic t_write_only;
    logic [31:0] d;
    rd(6'h04, d); chk("R14 cmd reads zero", d, 32'h0);
    rd(6'h2C, d); chk("R14 scl pull reads zero", d, 32'h0);
    rd(6'h30, d); chk("R14 sda release reads zero", d, 32'h0);
    rd(6'h34, d); chk("R14 sda pull reads zero", d, 32'h0);
    rd(6'h3C, d); chk("R14 unmapped reads zero", d, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    fifo_rdata = '0; eng_flags = '0; eng_busy = 1'b0; eng_fifo_count = '0;
    eng_resid = '0; eng_port_busy = 1'b0; far_scl = 1'b1; far_sda = 1'b1;
    eng_scl_low = 1'b0; eng_sda_low = 1'b0; scl_in = 1'b1; sda_in = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mode();
    t_mask();
    t_int_stat();
    t_xstat();
    t_actions();
    t_eng_reset();
    t_diag();
    t_nodiag();
    t_sync();
    t_pbusy();
    t_write_only();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule